// File: doc/BRIEF.md
# Flash Page Address Extender

This glue block sits between a processor with a narrow external address bus and a parallel flash array that is larger than the processor's window. The processor first writes a page number into a small I/O register. It then performs ordinary reads and writes through its memory window. The block places the latched page number on the upper flash address lines. The processor's own address bits, shifted down by one position, form the lower flash address.

The same I/O window also holds a control register. One bit of it drives the flash byte/word select pin, and another bit can hold the flash in reset. After a system reset the block holds the flash reset pin low for a fixed number of clocks and then releases it.

The memory strobes pass straight through to the flash output-enable and write-enable pins. They are gated by the memory chip-select so that I/O cycles never disturb the array. The I/O register space is decoded from the processor's low eight address bits. Register reads return their contents on the 16-bit data bus, with the unused upper bits cleared.

Top module: `flash_page_ext`

## Requirements
- R1: `flash_addr[12:0]` equals `cpu_addr[13:1]` at all times. This path is combinational.
- R2: `flash_addr[18:13]` equals the 6-bit page register.
- R3: The page register loads `cpu_wdata[5:0]` on a rising edge of `cpu_we_n`, when `io_cs_n` is low and `cpu_addr[7:0]` equals 0x10. The clock edge that sees `cpu_we_n` high, after it was low at the previous edge, performs the load. The new page appears on `flash_addr` right after that edge.
- R4: A write strobe has no effect on the page register in either of two cases: `io_cs_n` is high, or the I/O address differs from 0x10.
- R5: A read cycle needs `io_cs_n` low, `cpu_re_n` low and `cpu_addr[7:0]` = 0x10. It returns the page value on `io_rdata[5:0]`, with bits [15:6] zero, and raises `io_rd_en`. When no register is addressed for reading, `io_rdata` is zero and `io_rd_en` is low.
- R6: The control register sits at I/O address 0x11 and is written with the same strobe rule as R3. Bit 0 drives `flash_byte_n`, where 1 means word mode. Bit 1, when set, forces `flash_rst_n` low. Reading 0x11 returns both bits on `io_rdata[1:0]`, with the upper bits zero.
- R7: While `rst_n` is low, the page register is zero, `flash_byte_n` is 1 (word mode) and control bit 1 is 0.
- R8: After `rst_n` rises, `flash_rst_n` stays low for exactly `RST_CYCLES` (default 16) rising clock edges and goes high after the last of them.
- R9: `flash_oe_n` is `cpu_re_n` OR `mem_cs_n`, and `flash_we_n` is `cpu_we_n` OR `mem_cs_n`. Both are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 14 | Processor address bus |
| cpu_wdata | input | 16 | Processor write data |
| cpu_we_n | input | 1 | Processor write strobe, active low |
| cpu_re_n | input | 1 | Processor read strobe, active low |
| mem_cs_n | input | 1 | Memory-window chip-select, active low |
| io_cs_n | input | 1 | I/O-window chip-select, active low |
| io_rdata | output | 16 | Register read data |
| io_rd_en | output | 1 | High when `io_rdata` carries a register value |
| flash_addr | output | 19 | Flash word address |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low |
| flash_byte_n | output | 1 | Flash byte/word select, 1 = word mode |
| flash_rst_n | output | 1 | Flash reset, active low |

## Verification
Address, strobe and read-data results are combinational, so the bench samples them a short delay after it changes the inputs, within the same clock period. A register write takes effect at the first rising edge that sees the write strobe high again. The bench releases the strobe on a falling edge, keeps the chip-select low through the next rising edge, and checks `flash_addr`, `flash_byte_n` and `flash_rst_n` at the falling edge after that. The power-up reset pulse is counted edge by edge from the release of `rst_n`. It is checked low one edge before its end and high just after it.

// File: rtl/flash_page_ext.sv
module flash_page_ext #(
  parameter int CPU_AW     = 14,
  parameter int FLASH_AW   = 19,
  parameter int DW         = 16,
  parameter int IO_AW      = 8,
  parameter logic [7:0] PAGE_ADDR = 8'h10,
  parameter logic [7:0] CTRL_ADDR = 8'h11,
  parameter int RST_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CPU_AW-1:0]   cpu_addr,
  input  logic [DW-1:0]       cpu_wdata,
  input  logic                cpu_we_n,
  input  logic                cpu_re_n,
  input  logic                mem_cs_n,
  input  logic                io_cs_n,
  output logic [DW-1:0]       io_rdata,
  output logic                io_rd_en,
  output logic [FLASH_AW-1:0] flash_addr,
  output logic                flash_oe_n,
  output logic                flash_we_n,
  output logic                flash_byte_n,
  output logic                flash_rst_n
);
  localparam int LOW_W = CPU_AW - 1;
  localparam int PW    = FLASH_AW - LOW_W;
  localparam int CW    = $clog2(RST_CYCLES + 1);

  logic [PW-1:0] page_q;
  logic [1:0]    ctrl_q;
  logic          we_q;
  logic [CW-1:0] cnt_q;

  wire hit_page = (cpu_addr[IO_AW-1:0] == PAGE_ADDR[IO_AW-1:0]);
  wire hit_ctrl = (cpu_addr[IO_AW-1:0] == CTRL_ADDR[IO_AW-1:0]);
  wire wr_rise  = cpu_we_n && !we_q && !io_cs_n;
  wire rd_cyc   = !io_cs_n && !cpu_re_n;
  wire por_done = (cnt_q == CW'(RST_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b1;
      page_q <= '0;
      ctrl_q <= 2'b01;
      cnt_q  <= '0;
    end else begin
      we_q <= cpu_we_n;
      if (wr_rise && hit_page) page_q <= cpu_wdata[PW-1:0];
      if (wr_rise && hit_ctrl) ctrl_q <= cpu_wdata[1:0];
      if (!por_done) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign flash_addr   = {page_q, cpu_addr[CPU_AW-1:1]};
  assign flash_oe_n   = cpu_re_n | mem_cs_n;
  assign flash_we_n   = cpu_we_n | mem_cs_n;
  assign flash_byte_n = ctrl_q[0];
  assign flash_rst_n  = por_done && !ctrl_q[1];
  assign io_rd_en     = rd_cyc && (hit_page || hit_ctrl);

  always_comb begin
    io_rdata = '0;
    if (rd_cyc && hit_page) io_rdata[PW-1:0] = page_q;
    else if (rd_cyc && hit_ctrl) io_rdata[1:0] = ctrl_q;
  end

  // R3: a decoded write strobe edge loads the page lines
  p_page_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we_n && !we_q && !io_cs_n && hit_page)
      |=> flash_addr[FLASH_AW-1:LOW_W] == $past(cpu_wdata[PW-1:0]));

  // R4: without a decoded strobe edge the page lines hold
  p_page_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we_n && !we_q && !io_cs_n && hit_page)
      |=> $stable(flash_addr[FLASH_AW-1:LOW_W]));

  // R5: read data upper bits are always clear
  p_rd_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    io_rdata[DW-1:PW] == '0);

  // R8: flash reset stays asserted until the power-up count ends
  p_por_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q < CW'(RST_CYCLES)) |-> !flash_rst_n);

  // R9: strobes never reach the flash without memory select
  p_strobe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (flash_oe_n && flash_we_n));
endmodule

// File: tb/test_flash_page_ext.sv
module test_flash_page_ext;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [13:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_we_n = 1, cpu_re_n = 1, mem_cs_n = 1, io_cs_n = 1;
  logic [15:0] io_rdata;
  logic        io_rd_en;
  logic [18:0] flash_addr;
  logic        flash_oe_n, flash_we_n, flash_byte_n, flash_rst_n;

  int checks = 0, fails = 0;
  logic [5:0] m_page;
  logic [1:0] m_ctrl;

  always #10 clk = ~clk;

  flash_page_ext i_flash_page_ext (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we_n(cpu_we_n), .cpu_re_n(cpu_re_n), .mem_cs_n(mem_cs_n), .io_cs_n(io_cs_n),
    .io_rdata(io_rdata), .io_rd_en(io_rd_en), .flash_addr(flash_addr),
    .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n), .flash_byte_n(flash_byte_n),
    .flash_rst_n(flash_rst_n));

  function automatic logic [18:0] exp_addr(logic [5:0] pg, logic [13:0] a);
    return {pg, a[13:1]};
  endfunction

  function automatic logic [15:0] exp_rd(logic [7:0] a, logic [5:0] pg, logic [1:0] c);
    if (a == 8'h10) return {10'b0, pg};
    if (a == 8'h11) return {14'b0, c};
    return 16'h0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(logic [7:0] a, logic [15:0] d, logic cs_n);
    @(negedge clk);
    cpu_addr = {6'b0, a}; cpu_wdata = d; io_cs_n = cs_n; cpu_we_n = 0;
    @(negedge clk); @(negedge clk);
    cpu_we_n = 1;
    @(negedge clk);
    io_cs_n = 1;
    if (!cs_n && a == 8'h10) m_page = d[5:0];
    if (!cs_n && a == 8'h11) m_ctrl = d[1:0];
  endtask

  task automatic io_read_check(logic [7:0] a, string req);
    @(negedge clk);
    cpu_addr = {$urandom_range(63,0), a}; io_cs_n = 0; cpu_re_n = 0;
    #2;
    check(req, io_rdata, exp_rd(a, m_page, m_ctrl));
    check(req, io_rd_en, (a == 8'h10 || a == 8'h11));
    cpu_re_n = 1; io_cs_n = 1;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_page = 0; m_ctrl = 2'b01;
    repeat (3) @(negedge clk);
    cpu_addr = 14'h2ABC; #1;
    check("R7 page zero", flash_addr, exp_addr(6'd0, 14'h2ABC));
    check("R7 word mode", flash_byte_n, 1);
    check("R8 reset low", flash_rst_n, 0);
    rst_n = 1;
    repeat (15) @(negedge clk);
    check("R8 low before end", flash_rst_n, 0);
    @(negedge clk);
    check("R8 released", flash_rst_n, 1);

    // R9 strobe gating
    cpu_re_n = 0; mem_cs_n = 1; #1;
    check("R9 oe gated", flash_oe_n, 1);
    mem_cs_n = 0; #1;
    check("R9 oe pass", flash_oe_n, 0);
    check("R9 we idle", flash_we_n, 1);
    cpu_re_n = 1; cpu_we_n = 0; #1;
    check("R9 we pass", flash_we_n, 0);
    check("R9 oe idle", flash_oe_n, 1);
    cpu_we_n = 1; mem_cs_n = 1;

    // directed page corners
    io_write(8'h10, 16'hFFFF, 0);
    @(negedge clk); cpu_addr = 14'h3FFF; #1;
    check("R2 page max", flash_addr, exp_addr(m_page, 14'h3FFF));
    check("R1 low max", flash_addr[12:0], 13'h1FFF);
    io_read_check(8'h10, "R5 read page max");
    io_write(8'h10, 16'h0000, 1);
    @(negedge clk); #1;
    check("R4 cs high ignored", flash_addr[18:13], 6'h3F);
    io_write(8'h12, 16'h0000, 0);
    @(negedge clk); #1;
    check("R4 other addr ignored", flash_addr[18:13], 6'h3F);
    io_write(8'h10, 16'h0015, 0);
    @(negedge clk); cpu_addr = 14'h0001; #1;
    check("R3 page load", flash_addr, exp_addr(6'h15, 14'h0001));

    // control register
    io_write(8'h11, 16'h0000, 0);
    @(negedge clk); #1;
    check("R6 byte mode", flash_byte_n, 0);
    io_read_check(8'h11, "R6 read ctrl");
    io_write(8'h11, 16'h0003, 0);
    @(negedge clk); #1;
    check("R6 sw reset", flash_rst_n, 0);
    check("R6 word mode", flash_byte_n, 1);
    io_read_check(8'h11, "R6 read ctrl set");
    io_write(8'h11, 16'h0001, 0);
    @(negedge clk); #1;
    check("R6 sw reset cleared", flash_rst_n, 1);
    io_read_check(8'h33, "R5 unmapped read");

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [7:0] a;
      logic cs;
      logic [13:0] ma;
      a = ($urandom_range(3,0) == 0) ? 8'($urandom) : 8'h10;
      cs = ($urandom_range(4,0) == 0);
      io_write(a == 8'h11 ? 8'h10 : a, 16'($urandom), cs);
      @(negedge clk);
      ma = 14'($urandom); cpu_addr = ma; #1;
      check("R1 R2 R3 R4 random address", flash_addr, exp_addr(m_page, ma));
      io_read_check(8'h10, "R5 random readback");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule